// File: doc/BRIEF.md
# Priority Address Map Decoder

This block turns each bus address into a single chip select for one of six targets: a debug firmware window, a relocatable internal register window, SRAM, EEPROM, flash and external memory. Windows may overlap. Where they do, the target higher in a fixed precedence gets the select and the others stay low. The decode is purely combinational from the address, the strobe and the mode flags. Only the register window base is held in a flop.

The register window is 2 kB wide. It can sit on any 2 kB boundary in the lower 32 kB of the 64 kB space. Its position comes from an 8-bit base control register, and software writes that register through a plain write enable and data bus. In normal operation only the first write after reset is taken. In special mode every write is taken.

The address strobe has no ready and no back-pressure, because a decode never stalls. A select is meaningful in exactly the cycles where the strobe is high. The base register port is a plain control port.

Top module: `addr_map_decoder`

## Requirements
- R1: With the strobe high, at most one select is high. It goes to the highest-precedence claimant, in the order debug, register, SRAM, EEPROM, flash, external (highest first). Select bit order in this brief follows the same list.
- R2: The debug window covers 0xFF00–0xFFFF. It claims only while `dbg_active_i` is high, and it then wins over flash, which also covers that range.
- R3: The register window claims any address whose bits 15:11 equal bits 7:3 of the base register read-back.
- R4: The base register read-back resets to 0x00. Bit 7 and bits 2:0 always read zero, whatever was written.
- R5: With `special_mode_i` low, a write is taken only if no write has been taken since reset. Later writes leave the read-back unchanged.
- R6: With `special_mode_i` high, every write is taken and stored as `wdata & 0x78`.
- R7: A taken write changes the read-back and the register window decode from the cycle after the write cycle. The decode during the write cycle itself uses the old base.
- R8: With `expanded_mode_i` high, an address that no internal window claims selects external memory. With it low, such an address selects nothing.
- R9: The fixed windows are SRAM 0x2000–0x3FFF, EEPROM 0x4000–0x4FFF and flash 0x8000–0xFFFF.
- R10: With the strobe low, all selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| addr_vld_i | input | 1 | Address strobe; selects are valid while high |
| cfg_we_i | input | 1 | Write enable for the base control register |
| cfg_wdata_i | input | 8 | Write data for the base control register |
| special_mode_i | input | 1 | High: base register accepts unlimited writes |
| expanded_mode_i | input | 1 | High: unclaimed addresses go to external memory |
| dbg_active_i | input | 1 | High: debug firmware window takes part in decode |
| sel_dbg_o | output | 1 | Debug firmware select |
| sel_reg_o | output | 1 | Internal register window select |
| sel_sram_o | output | 1 | SRAM select |
| sel_eeprom_o | output | 1 | EEPROM select |
| sel_flash_o | output | 1 | Flash select |
| sel_ext_o | output | 1 | External memory select |
| cfg_rdata_o | output | 8 | Read-back of the base control register |

## Verification
The selects are due in the same cycle as the address, strobe and mode flags. The bench therefore drives those inputs just after a falling edge and compares the selects one nanosecond later, before the next rising edge. A base write is due one rising edge after the cycle that carries it. The bench checks the old decode inside the write cycle and checks the read-back and the new decode at the following falling edge. The lock and the repeated-write rules are judged only through the read-back and the moved register window.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

  // Decode targets, index 0 is highest precedence.
  localparam int NUM_TGT = 6;

  typedef enum logic [2:0] {
    TGT_DBG    = 3'd0,
    TGT_REG    = 3'd1,
    TGT_SRAM   = 3'd2,
    TGT_EEPROM = 3'd3,
    TGT_FLASH  = 3'd4,
    TGT_EXT    = 3'd5
  } tgt_e;

endpackage

// File: rtl/addr_window_match.sv
module addr_window_match #(
  parameter int ADDR_W   = 16,
  parameter int SIZE_LOG = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o
);

  // Aligned power-of-two window: upper bits must agree.
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff  = addr_i ^ base_i;
    hit_o = ((diff >> SIZE_LOG) == '0);
  end

endmodule

// File: rtl/addr_base_reg.sv
module addr_base_reg #(
  parameter int CFG_W     = 8,
  parameter int FIELD_W   = 4,
  parameter int FIELD_LSB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [CFG_W-1:0]   wdata_i,
  input  logic               special_i,
  output logic [CFG_W-1:0]   rdata_o,
  output logic [FIELD_W-1:0] field_o
);

  localparam logic [CFG_W-1:0] WR_MASK =
    CFG_W'(((1 << FIELD_W) - 1) << FIELD_LSB);

  logic [CFG_W-1:0] cfg_q;
  logic             taken_q;
  logic             accept;

  // Normal mode: first write only. Special mode: every write.
  always_comb accept = we_i && (special_i || !taken_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      taken_q <= 1'b0;
    end else if (accept) begin
      cfg_q   <= wdata_i & WR_MASK;
      taken_q <= 1'b1;
    end
  end

  assign rdata_o = cfg_q;
  assign field_o = cfg_q[FIELD_LSB +: FIELD_W];

endmodule

// File: rtl/addr_priority_pick.sv
module addr_priority_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] claim_i,
  output logic [N-1:0] grant_o
);

  // Bit 0 wins; each later bit is masked by any earlier claim.
  logic taken;

  always_comb begin
    taken   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      grant_o[i] = claim_i[i] && !taken;
      taken      = taken || claim_i[i];
    end
  end

endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder #(
  parameter int               ADDR_W       = 16,
  parameter int               CFG_W        = 8,
  parameter int               REG_WIN_LOG  = 11,
  parameter int               REG_SPAN_LOG = 15,
  parameter logic [ADDR_W-1:0] DBG_BASE    = 16'hFF00,
  parameter int               DBG_LOG      = 8,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 16'h2000,
  parameter int               SRAM_LOG     = 13,
  parameter logic [ADDR_W-1:0] EE_BASE     = 16'h4000,
  parameter int               EE_LOG       = 12,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 16'h8000,
  parameter int               FLASH_LOG    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              special_mode_i,
  input  logic              expanded_mode_i,
  input  logic              dbg_active_i,
  output logic              sel_dbg_o,
  output logic              sel_reg_o,
  output logic              sel_sram_o,
  output logic              sel_eeprom_o,
  output logic              sel_flash_o,
  output logic              sel_ext_o,
  output logic [CFG_W-1:0]  cfg_rdata_o
);

  import addr_map_pkg::*;

  localparam int FIELD_W   = REG_SPAN_LOG - REG_WIN_LOG;
  localparam int FIELD_LSB = CFG_W - 1 - FIELD_W;
  localparam int NUM_FIX   = 4;

  localparam logic [ADDR_W-1:0] FIX_BASE [NUM_FIX] =
    '{DBG_BASE, SRAM_BASE, EE_BASE, FLASH_BASE};
  localparam int FIX_LOG [NUM_FIX] = '{DBG_LOG, SRAM_LOG, EE_LOG, FLASH_LOG};

  logic [FIELD_W-1:0] reg_field;
  logic [ADDR_W-1:0]  reg_base;
  logic [NUM_FIX-1:0] fix_hit;
  logic               reg_hit;
  logic [NUM_TGT-1:0] claim;
  logic [NUM_TGT-1:0] grant;

  addr_base_reg #(
    .CFG_W    (CFG_W),
    .FIELD_W  (FIELD_W),
    .FIELD_LSB(FIELD_LSB)
  ) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .special_i(special_mode_i),
    .rdata_o  (cfg_rdata_o),
    .field_o  (reg_field)
  );

  assign reg_base = ADDR_W'(reg_field) << REG_WIN_LOG;

  addr_window_match #(
    .ADDR_W  (ADDR_W),
    .SIZE_LOG(REG_WIN_LOG)
  ) u_reg_win (
    .addr_i(addr_i),
    .base_i(reg_base),
    .hit_o (reg_hit)
  );

  for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix
    addr_window_match #(
      .ADDR_W  (ADDR_W),
      .SIZE_LOG(FIX_LOG[g])
    ) u_win (
      .addr_i(addr_i),
      .base_i(FIX_BASE[g]),
      .hit_o (fix_hit[g])
    );
  end

  always_comb begin
    claim             = '0;
    claim[TGT_DBG]    = addr_vld_i && dbg_active_i && fix_hit[0];
    claim[TGT_REG]    = addr_vld_i && reg_hit;
    claim[TGT_SRAM]   = addr_vld_i && fix_hit[1];
    claim[TGT_EEPROM] = addr_vld_i && fix_hit[2];
    claim[TGT_FLASH]  = addr_vld_i && fix_hit[3];
    claim[TGT_EXT]    = addr_vld_i && expanded_mode_i;
  end

  addr_priority_pick #(.N(NUM_TGT)) u_pick (
    .claim_i(claim),
    .grant_o(grant)
  );

  assign sel_dbg_o    = grant[TGT_DBG];
  assign sel_reg_o    = grant[TGT_REG];
  assign sel_sram_o   = grant[TGT_SRAM];
  assign sel_eeprom_o = grant[TGT_EEPROM];
  assign sel_flash_o  = grant[TGT_FLASH];
  assign sel_ext_o    = grant[TGT_EXT];

endmodule

// File: rtl/addr_map_checker.sv
module addr_map_checker #(
  parameter int                ADDR_W      = 16,
  parameter int                CFG_W       = 8,
  parameter int                REG_WIN_LOG = 11,
  parameter logic [ADDR_W-1:0] DBG_BASE    = 16'hFF00,
  parameter int                DBG_LOG     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              addr_vld_i,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic              special_mode_i,
  input logic              expanded_mode_i,
  input logic              dbg_active_i,
  input logic              sel_dbg_o,
  input logic              sel_reg_o,
  input logic              sel_sram_o,
  input logic              sel_eeprom_o,
  input logic              sel_flash_o,
  input logic              sel_ext_o,
  input logic [CFG_W-1:0]  cfg_rdata_o
);

  logic [5:0] sels;
  logic       seen_wr;
  logic       in_dbg;
  logic       in_reg;

  assign sels   = {sel_ext_o, sel_flash_o, sel_eeprom_o,
                   sel_sram_o, sel_reg_o, sel_dbg_o};
  assign in_dbg = ((addr_i ^ DBG_BASE) >> DBG_LOG) == '0;
  assign in_reg = (addr_i >> REG_WIN_LOG) == ADDR_W'(cfg_rdata_o >> 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_wr <= 1'b0;
    else if (cfg_we_i) seen_wr <= 1'b1;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld_i |-> (sels == '0));

  a_r2_dbg_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_i && dbg_active_i && in_dbg) |-> sel_dbg_o);

  a_r2_dbg_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_active_i |-> !sel_dbg_o);

  a_r3_reg_window: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_i && in_reg && !(dbg_active_i && in_dbg)) |-> sel_reg_o);

  a_r4_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata_o & 8'h87) == 8'h00);

  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !special_mode_i && seen_wr) |=> $stable(cfg_rdata_o));

  a_r6_r7_take: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && (special_mode_i || !seen_wr))
      |=> (cfg_rdata_o == ($past(cfg_wdata_i) & 8'h78)));

  a_r8_ext_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_i && expanded_mode_i) |-> (sels != '0));

endmodule

bind addr_map_decoder addr_map_checker #(
  .ADDR_W     (ADDR_W),
  .CFG_W      (CFG_W),
  .REG_WIN_LOG(REG_WIN_LOG),
  .DBG_BASE   (DBG_BASE),
  .DBG_LOG    (DBG_LOG)
) u_chk (.*);

// File: tb/tb_addr_map_decoder.sv
module tb_addr_map_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        vld = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic        spec = 1'b0;
  logic        expd = 1'b0;
  logic        dbg = 1'b0;
  logic        s_dbg, s_reg, s_sram, s_ee, s_fl, s_ext;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .addr_vld_i(vld),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .special_mode_i(spec),
    .expanded_mode_i(expd), .dbg_active_i(dbg),
    .sel_dbg_o(s_dbg), .sel_reg_o(s_reg), .sel_sram_o(s_sram),
    .sel_eeprom_o(s_ee), .sel_flash_o(s_fl), .sel_ext_o(s_ext),
    .cfg_rdata_o(rdata)
  );

  // Expected select vector, bit 0 = debug ... bit 5 = external.
  function automatic logic [5:0] model(input logic [15:0] a, input logic [7:0] cfg,
                                       input logic d, input logic x, input logic v);
    logic [5:0] c;
    logic [5:0] r;
    c[0] = d && (a >= 16'hFF00);
    c[1] = (a / 16'd2048) == 16'(cfg / 8'd8);
    c[2] = (a >= 16'h2000) && (a < 16'h4000);
    c[3] = (a >= 16'h4000) && (a < 16'h5000);
    c[4] = (a >= 16'h8000);
    c[5] = x;
    r = '0;
    if (v) begin
      for (int k = 0; k < 6; k++) begin
        if (c[k]) begin
          r[k] = 1'b1;
          break;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [5:0] got();
    return {s_ext, s_fl, s_ee, s_sram, s_reg, s_dbg};
  endfunction

  task automatic chk_sel(input string tag, input logic [5:0] exp_v);
    checks++;
    if (got() !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h sel=%b expected=%b", tag, addr, got(), exp_v);
    end
  endtask

  task automatic chk_cfg(input string tag, input logic [7:0] exp_v);
    checks++;
    if (rdata !== exp_v) begin
      errors++;
      $display("FAIL %s rdata=%h expected=%h", tag, rdata, exp_v);
    end
  endtask

  // Apply address in a fresh cycle and compare before the next rising edge.
  task automatic probe(input logic [15:0] a, input logic v, input string tag,
                       input logic [5:0] exp_v);
    @(negedge clk);
    addr = a;
    vld  = v;
    #1;
    chk_sel(tag, exp_v);
  endtask

  // One-cycle write; read-back is due at the following falling edge.
  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    we    = 1'b1;
    wdata = d;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    we    = 1'b0;
    vld   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] cfgs [4] = '{8'h00, 8'h20, 8'h40, 8'h78};
    logic [7:0] cur;

    do_reset();
    #1;
    chk_cfg("R4 reset value", 8'h00);
    probe(16'h0000, 1'b1, "R3 reset base at zero", 6'b000010);
    probe(16'h07FF, 1'b1, "R3 top of reset window", 6'b000010);
    probe(16'h0800, 1'b1, "R8 single-chip unclaimed", 6'b000000);
    probe(16'h2000, 1'b0, "R10 strobe low", 6'b000000);

    // Normal mode lock.
    spec = 1'b0;
    wr(8'hDA);
    #1;
    chk_cfg("R4 R5 first write masked", 8'h58);
    probe(16'h5800, 1'b1, "R3 R5 moved window", 6'b000010);
    wr(8'h20);
    #1;
    chk_cfg("R5 second write ignored", 8'h58);
    probe(16'h2000, 1'b1, "R5 window not moved by ignored write", 6'b000100);

    // Special mode repeated writes and one-cycle latency.
    spec = 1'b1;
    wr(8'hFF);
    #1;
    chk_cfg("R4 R6 all-ones write masked", 8'h78);
    @(negedge clk);
    addr  = 16'h1000;
    vld   = 1'b1;
    we    = 1'b1;
    wdata = 8'h10;
    #1;
    chk_sel("R7 old base during write cycle", 6'b000000);
    @(negedge clk);
    we = 1'b0;
    #1;
    chk_sel("R7 new base after write cycle", 6'b000010);
    chk_cfg("R6 R7 read-back after write", 8'h10);

    // Sweeps over bases and mode flags.
    foreach (cfgs[ci]) begin
      wr(cfgs[ci]);
      cur = cfgs[ci];
      #1;
      chk_cfg("R6 sweep base write", cur);
      for (int m = 0; m < 4; m++) begin
        dbg  = m[0];
        expd = m[1];
        probe(16'hFF80, 1'b0, "R10 strobe low sweep", 6'b000000);
        for (int i = 0; i < 4096; i++) begin
          logic [15:0] a;
          a = 16'(i * 16 + (i % 16));
          probe(a, 1'b1, "R1 R2 R3 R8 R9 sweep", model(a, cur, dbg, expd, 1'b1));
        end
      end
    end

    // Targeted precedence corners.
    dbg  = 1'b1;
    expd = 1'b1;
    probe(16'hFF00, 1'b1, "R2 debug over flash", 6'b000001);
    dbg = 1'b0;
    probe(16'hFF00, 1'b1, "R2 flash when debug idle", 6'b010000);
    probe(16'h4FFF, 1'b1, "R9 EEPROM top", 6'b001000);
    probe(16'h5000, 1'b1, "R8 expanded fill", 6'b100000);
    wr(8'h40);
    probe(16'h4400, 1'b1, "R1 register over EEPROM", 6'b000010);
    probe(16'h4800, 1'b1, "R9 EEPROM past register window", 6'b001000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule